// File: doc/BRIEF.md
# One-Time-Programmable Security Register

This block holds a 128-byte security register made of two halves. The lower 64 bytes are a user area that can be written only once. The upper 64 bytes are a factory identifier that is fixed at build time through a parameter and can never be written. A byte-addressed read port reaches all 128 bytes.

The user area is filled in a single transaction. Its data comes from an external 64-byte staging buffer. When a program request arrives and the user area is still blank, the block walks the buffer one byte per clock. It copies each byte into the user area and writes 0xFF back into the buffer slot it has just consumed. When the walk ends, a sticky flag is raised, and every later request is ignored. The command decoding that issues the request strobe lives outside this block.

Top module: `otp_secreg`

## Requirements
- R1: After reset, `busy` and `programmed` are 0 and every user byte (addresses 0 to 63) reads as 0xFF.
- R2: `rdData` shows the byte at the `rdAddr` value sampled on the previous rising edge (one cycle of latency). Address bit 6 selects the factory half (1) or the user half (0).
- R3: The factory byte at address 64+i (i = 0..63) equals ((i*37 + FACTORY_SEED) mod 256) XOR 0x5A. It never changes, whatever requests are made.
- R4: A `progReq` sampled high while idle and not yet programmed raises `busy` on the next cycle. `busy` then stays high for exactly 64 cycles, and `bufAddr` steps 0,1,…,63, one value per busy cycle.
- R5: After programming, user byte i reads the value the staging buffer held at address i when that address was visited.
- R6: `programmed` rises in the same cycle that `busy` falls, and it stays high until reset.
- R7: In every busy cycle, `bufWrEn` is 1 and `bufWrData` is 0xFF at the current `bufAddr`, so the whole buffer reads 0xFF after programming. Outside busy cycles, `bufWrEn` is 0.
- R8: A `progReq` while `programmed` is 1 is ignored. `busy` stays 0, the buffer is not written, and all 128 register bytes keep their values.
- R9: A `progReq` arriving while `busy` is high neither restarts nor extends the copy. The copy still ends 64 cycles after it began.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| progReq | input | 1 | Program request strobe |
| bufAddr | output | 6 | Staging buffer address during the copy |
| bufRdData | input | 8 | Staging buffer data at `bufAddr` (combinational read) |
| bufWrEn | output | 1 | Staging buffer write enable |
| bufWrData | output | 8 | Staging buffer write data (0xFF) |
| rdAddr | input | 7 | Register read address |
| rdData | output | 8 | Registered read data |
| busy | output | 1 | Copy in progress |
| programmed | output | 1 | User area has been written |

## Verification
The assertions assume that the staging buffer returns the addressed byte in the same cycle, with no wait states. They also assume that `progReq` and `rdAddr` are synchronous to `clk` and carry no unknown values once reset is released. The bench models the buffer as an array with combinational read and writes at the clock edge, and it drives every input at the falling edge. It issues a second request during the copy and a third after programming, so that both ignore paths are exercised while the bench still watches the interface.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int USER_BYTES  = 64;
  localparam int TOTAL_BYTES = 2 * USER_BYTES;
  localparam int IDX_W       = $clog2(USER_BYTES);
  localparam int ADDR_W      = $clog2(TOTAL_BYTES);
  localparam int ID_MULT     = 37;
  localparam logic [7:0] ID_MASK    = 8'h5A;
  localparam logic [7:0] BLANK_BYTE = 8'hFF;

  // strobes from control to datapath
  typedef struct packed {
    logic             copyEn;
    logic [IDX_W-1:0] idx;
  } otpStrobe_t;

  function automatic logic [7:0] factoryByte(input int unsigned i, input logic [7:0] seed);
    logic [31:0] sum;
    sum = i * ID_MULT + 32'(seed);
    return sum[7:0] ^ ID_MASK;
  endfunction
endpackage

// File: rtl/otp_ctrl.sv
module otp_ctrl
  import otp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       progReq,
  output otpStrobe_t strb,
  output logic       busy,
  output logic       programmed
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(USER_BYTES - 1);

  typedef enum logic {ST_IDLE, ST_COPY} ctrlState_t;
  ctrlState_t       state;
  logic [IDX_W-1:0] copyIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      copyIdx    <= '0;
      programmed <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          copyIdx <= '0;
          if (progReq && !programmed) state <= ST_COPY;
        end
        ST_COPY: begin
          copyIdx <= copyIdx + 1'b1;
          if (copyIdx == LAST_IDX) begin
            state      <= ST_IDLE;
            programmed <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy        = (state == ST_COPY);
    strb.copyEn = busy;
    strb.idx    = copyIdx;
  end
endmodule

// File: rtl/otp_datapath.sv
module otp_datapath
  import otp_pkg::*;
#(
  parameter logic [7:0] FACTORY_SEED = 8'h6C
) (
  input  logic              clk,
  input  logic              rstN,
  input  otpStrobe_t        strb,
  input  logic [7:0]        bufRdData,
  output logic [IDX_W-1:0]  bufAddr,
  output logic              bufWrEn,
  output logic [7:0]        bufWrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);
  logic [7:0] userMem [USER_BYTES];
  logic [7:0] factRom [USER_BYTES];

  for (genvar g = 0; g < USER_BYTES; g++) begin : g_rom
    assign factRom[g] = factoryByte(g, FACTORY_SEED);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < USER_BYTES; i++) userMem[i] <= BLANK_BYTE;
    end else if (strb.copyEn) begin
      userMem[strb.idx] <= bufRdData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (rdAddr[ADDR_W-1]) rdData <= factRom[rdAddr[IDX_W-1:0]];
    else rdData <= userMem[rdAddr[IDX_W-1:0]];
  end

  always_comb begin
    bufAddr   = strb.idx;
    bufWrEn   = strb.copyEn;
    bufWrData = BLANK_BYTE;
  end
endmodule

// File: rtl/otp_secreg.sv
module otp_secreg
  import otp_pkg::*;
#(
  parameter logic [7:0] FACTORY_SEED = 8'h6C
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       progReq,
  output logic [5:0] bufAddr,
  input  logic [7:0] bufRdData,
  output logic       bufWrEn,
  output logic [7:0] bufWrData,
  input  logic [6:0] rdAddr,
  output logic [7:0] rdData,
  output logic       busy,
  output logic       programmed
);
  otpStrobe_t strb;

  otp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .progReq(progReq),
    .strb(strb), .busy(busy), .programmed(programmed)
  );

  otp_datapath #(.FACTORY_SEED(FACTORY_SEED)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bufRdData(bufRdData),
    .bufAddr(bufAddr), .bufWrEn(bufWrEn), .bufWrData(bufWrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/otp_secreg_chk.sv
module otp_secreg_chk
  import otp_pkg::*;
#(
  parameter logic [7:0] FACTORY_SEED = 8'h6C
) (
  input logic       clk,
  input logic       rstN,
  input logic       progReq,
  input logic [5:0] bufAddr,
  input logic       bufWrEn,
  input logic [7:0] bufWrData,
  input logic [6:0] rdAddr,
  input logic [7:0] rdData,
  input logic       busy,
  input logic       programmed
);
  logic [7:0] busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else busyRun <= '0;
  end

  p_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !programmed && progReq) |=> busy);
  p_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == 8'(USER_BYTES)));
  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (bufAddr == $past(bufAddr) + 6'd1));
  p_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (bufAddr == 6'd0));
  p_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> programmed);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    programmed |=> programmed);
  p_bufwr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bufWrEn == busy) && (!bufWrEn || bufWrData == 8'hFF));
  p_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    (programmed && !busy) |=> !busy);
  p_factory_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdAddr[6] |=> (rdData == factoryByte(32'($past(rdAddr[5:0])), FACTORY_SEED)));
endmodule

bind otp_secreg otp_secreg_chk #(.FACTORY_SEED(FACTORY_SEED)) u_chk (
  .clk(clk), .rstN(rstN), .progReq(progReq), .bufAddr(bufAddr),
  .bufWrEn(bufWrEn), .bufWrData(bufWrData), .rdAddr(rdAddr),
  .rdData(rdData), .busy(busy), .programmed(programmed)
);

// File: tb/sim_otp_secreg.sv
module sim_otp_secreg;
  localparam logic [7:0] SEED = 8'h6C;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       progReq = 1'b0;
  logic [5:0] bufAddr;
  logic [7:0] bufRdData;
  logic       bufWrEn;
  logic [7:0] bufWrData;
  logic [6:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       busy, programmed;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  // staging buffer model, plus a host fill port
  logic [7:0] bufMem [64];
  logic       hostWe = 1'b0;
  logic [5:0] hostAddr = '0;
  logic [7:0] hostData = '0;
  assign bufRdData = bufMem[bufAddr];
  always @(posedge clk) begin
    if (bufWrEn) bufMem[bufAddr] <= bufWrData;
    else if (hostWe) bufMem[hostAddr] <= hostData;
  end

  otp_secreg #(.FACTORY_SEED(SEED)) u0 (
    .clk(clk), .rstN(rstN), .progReq(progReq), .bufAddr(bufAddr),
    .bufRdData(bufRdData), .bufWrEn(bufWrEn), .bufWrData(bufWrData),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .programmed(programmed)
  );

  function automatic logic [7:0] expFactory(int i);
    logic [31:0] s;
    s = i * 37 + 32'(SEED);
    return s[7:0] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] patA(int i);
    return 8'((i * 7 + 3) ^ 8'hC3);
  endfunction
  function automatic logic [7:0] patB(int i);
    return 8'(i * 11 + 5);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard for the read port
  typedef struct { logic [6:0] addr; logic [7:0] exp; string req; } rdItem_t;
  rdItem_t pendQ[$];

  task automatic readExpect(input logic [6:0] a, input logic [7:0] e, input string req);
    rdItem_t it;
    @(negedge clk);
    rdAddr = a;
    it.addr = a; it.exp = e; it.req = req;
    pendQ.push_back(it);
  endtask

  always @(posedge clk) begin
    if (pendQ.size() > 0) begin
      rdItem_t it;
      it = pendQ.pop_front();
      #1;
      check(it.req, {24'd0, rdData}, {24'd0, it.exp});
    end
  end

  task automatic fillBuf(input bit useB);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      hostWe = 1'b1; hostAddr = 6'(i);
      hostData = useB ? patB(i) : patA(i);
    end
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic drainReads();
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int busyCnt;
    int addrErr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", {31'd0, busy}, 0);
    check("R1 programmed after reset", {31'd0, programmed}, 0);
    readExpect(7'd0, 8'hFF, "R1 blank user byte 0");
    readExpect(7'd37, 8'hFF, "R1 blank user byte 37");
    readExpect(7'd63, 8'hFF, "R1 blank user byte 63");
    for (int i = 0; i < 64; i++) readExpect(7'(64 + i), expFactory(i), "R3 R2 factory byte");
    drainReads();

    fillBuf(1'b0);
    // program request (R4), second request mid-copy (R9)
    @(negedge clk); progReq = 1'b1;
    @(negedge clk); progReq = 1'b0;
    busyCnt = 0; addrErr = 0;
    while (busy && busyCnt < 200) begin
      if (bufAddr != 6'(busyCnt) || !bufWrEn) addrErr++;
      busyCnt++;
      if (busyCnt == 10) progReq = 1'b1;
      if (busyCnt == 11) progReq = 1'b0;
      @(negedge clk);
    end
    check("R4 R9 busy length", busyCnt, 64);
    check("R4 R7 buffer address walk", addrErr, 0);
    check("R6 programmed after copy", {31'd0, programmed}, 1);
    check("R7 no buffer write after copy", {31'd0, bufWrEn}, 0);
    begin
      int notBlank = 0;
      for (int i = 0; i < 64; i++) if (bufMem[i] !== 8'hFF) notBlank++;
      check("R7 buffer reads 0xFF", notBlank, 0);
    end
    for (int i = 0; i < 64; i++) readExpect(7'(i), patA(i), "R5 user byte copied");
    drainReads();

    // R8: request after programming is ignored
    fillBuf(1'b1);
    @(negedge clk); progReq = 1'b1;
    @(negedge clk); progReq = 1'b0;
    busyCnt = 0;
    repeat (8) begin
      if (busy || bufWrEn) busyCnt++;
      @(negedge clk);
    end
    check("R8 no busy on repeat request", busyCnt, 0);
    check("R8 R6 programmed stays", {31'd0, programmed}, 1);
    begin
      int changed = 0;
      for (int i = 0; i < 64; i++) if (bufMem[i] !== patB(i)) changed++;
      check("R8 buffer untouched", changed, 0);
    end
    for (int i = 0; i < 64; i += 9) readExpect(7'(i), patA(i), "R8 user byte unchanged");
    for (int i = 0; i < 64; i += 7) readExpect(7'(64 + i), expFactory(i), "R3 factory unchanged");
    drainReads();

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule